// File: doc/BRIEF.md
# Mixed-Radix Spacecraft Timestamp Counter

This block keeps the onboard time of a spacecraft as a cascade of four counters. A sub-step count runs modulo 8 and carries into a real-time-interrupt count that runs modulo 10. That count carries into a frame count that runs modulo 91, and the frame count carries into a 24-bit image-cycle count that wraps only after 16777215. A single-cycle base tick strobe advances the whole cascade. The four fields are packed into one 48-bit word. A ground command can overwrite that word at any time.

When a frame-sync start strobe arrives, the block captures the time as it stood at that edge. It offers this capture on a valid/ready output stream, so each frame carries the time of the first bit of its sync code. At low data rates the sub-step field of the capture is forced to zero. A telemetry-mode change is requested through a valid/ready input. The request is held pending and takes effect only on the tick where the frame count rolls from 90 to 0 and the image-cycle count steps.

Back-pressure rules: the mode input is accepted on a cycle where valid and ready are both high. Ready stays low while a request is pending, so a second request waits at the sender. The capture output holds its data stable while valid is high and ready is low. A new sync strobe always overwrites the held capture (newest wins), even one that has not yet been taken.

Top module: `sct_timestamp`

## Requirements
- R1: A synchronous active-high reset clears the time word to zero, clears the active mode to 0, deasserts capture valid and asserts mode-request ready.
- R2: Each tick without a load adds one to the sub-step field (bits 7:0). From 7 it returns to 0 and adds one to the interrupt field (bits 15:8).
- R3: The interrupt field returns from 9 to 0 and carries into the frame field (bits 23:16). The frame field returns from 90 to 0 and carries into the image-cycle field (bits 47:24), so 7280 ticks from zero give image-cycle 1 with all lower fields 0.
- R4: A carry into an image-cycle field of 16777215 makes it 0. The lower fields are then 0 as well.
- R5: With no tick and no load, the time word keeps its value.
- R6: A load writes the load word into the time word on the next edge and takes priority over a tick in the same cycle. A sub-field whose loaded value is at or above its modulus (8, 10, 91) is written as 0.
- R7: A sync strobe captures the time word as it stood before that edge, including when a tick arrives in the same cycle. Capture valid is high on the next cycle.
- R8: The sub-step field of a capture is 0 when the high-rate input was low at the sync strobe. It equals the live sub-step value when that input was high.
- R9: Capture valid stays high with stable data until a cycle with ready high. On that cycle, without a new sync, valid drops. A sync in the same cycle keeps valid high with new data.
- R10: A mode request is accepted when its valid and ready are both high, and ready then stays low. The active mode changes only on the tick that rolls the frame field from 90 to 0, where it takes the pending value and ready returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Base tick strobe, one cycle |
| load_i | input | 1 | Ground load of the whole time word |
| load_value_i | input | 48 | Value for the load, packed like stamp_o |
| high_rate_i | input | 1 | High when the frame rate is above the low-rate threshold |
| frame_sync_i | input | 1 | Frame-sync start strobe |
| stamp_o | output | 48 | Live time {image, frame, interrupt, sub-step} |
| frame_stamp_valid_o | output | 1 | Capture available |
| frame_stamp_ready_i | input | 1 | Capture taken by consumer |
| frame_stamp_o | output | 48 | Captured time |
| mode_req_valid_i | input | 1 | Mode request offered |
| mode_req_i | input | 4 | Requested mode |
| mode_req_ready_o | output | 1 | No request pending |
| mode_o | output | 4 | Active telemetry mode |

## Verification
The carry chain is driven with an unbroken tick train across a full 8×10×91 period, which shows whether each modulus and each carry is right. A single tick from an all-maximum load shows the 24-bit wrap apart from the normal carries. Loads with out-of-range sub-fields, and a load together with a tick, show the clamp and the priority. Sync strobes that arrive with a tick, at both rate settings and under back-pressure, show whether the capture is taken before or after the edge, whether the rate masking works, and how overwrite and drain behave. A mode request followed by ticks up to and across the rollover shows deferred application apart from immediate application.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int NUM_FIELDS = 4;

  // Width of cascade stage idx: stages 0..2 are sub-fields, stage 3 the image count
  function automatic int field_width(int idx, int sub_w, int rim_w);
    return (idx == NUM_FIELDS - 1) ? rim_w : sub_w;
  endfunction

  // Modulus of cascade stage idx
  function automatic int field_limit(int idx, int mod_a, int mod_b, int mod_c, int rim_w);
    case (idx)
      0:       return mod_a;
      1:       return mod_b;
      2:       return mod_c;
      default: return 2 ** rim_w;
    endcase
  endfunction
endpackage

// File: rtl/sct_field.sv
module sct_field #(
  parameter int W     = 8,
  parameter int LIMIT = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step_in,
  output logic [W-1:0] value,
  output logic         carry_out
);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic at_top;
  logic load_legal;

  assign at_top     = (value == TOP);
  assign load_legal = (64'(load_val) < 64'(LIMIT));
  assign carry_out  = step_in && at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (load_en) begin
      value <= load_legal ? load_val : '0;
    end else if (step_in) begin
      value <= at_top ? '0 : value + 1'b1;
    end
  end
endmodule

// File: rtl/sct_snap.sv
module sct_snap #(
  parameter int STAMP_W = 48,
  parameter int LOW_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_in,
  input  logic               high_rate,
  input  logic [STAMP_W-1:0] stamp_in,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [STAMP_W-1:0] out_data
);
  logic [STAMP_W-1:0] masked;

  assign masked = {stamp_in[STAMP_W-1:LOW_W], (high_rate ? stamp_in[LOW_W-1:0] : LOW_W'(0))};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (sync_in) begin
      out_valid <= 1'b1;
      out_data  <= masked;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sct_mode.sv
module sct_mode #(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_data,
  output logic              req_ready,
  input  logic              boundary,
  output logic [MODE_W-1:0] mode
);
  logic              pend_v;
  logic [MODE_W-1:0] pend;

  assign req_ready = !pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend   <= '0;
      mode   <= '0;
    end else begin
      if (req_valid && req_ready) begin
        pend_v <= 1'b1;
        pend   <= req_data;
      end
      if (boundary && pend_v) begin
        mode   <= pend;
        pend_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sct_timestamp.sv
module sct_timestamp #(
  parameter int RIM_W  = 24,
  parameter int SUB_W  = 8,
  parameter int MOD_A  = 8,
  parameter int MOD_B  = 10,
  parameter int MOD_C  = 91,
  parameter int MODE_W = 4,
  localparam int STAMP_W = RIM_W + 3 * SUB_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [STAMP_W-1:0] load_value_i,
  input  logic               high_rate_i,
  input  logic               frame_sync_i,
  output logic [STAMP_W-1:0] stamp_o,
  output logic               frame_stamp_valid_o,
  input  logic               frame_stamp_ready_i,
  output logic [STAMP_W-1:0] frame_stamp_o,
  input  logic               mode_req_valid_i,
  input  logic [MODE_W-1:0]  mode_req_i,
  output logic               mode_req_ready_o,
  output logic [MODE_W-1:0]  mode_o
);
  import sct_pkg::*;

  logic [NUM_FIELDS:0] carry;

  assign carry[0] = tick_i && !load_i;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam int FW  = field_width(i, SUB_W, RIM_W);
    localparam int LIM = field_limit(i, MOD_A, MOD_B, MOD_C, RIM_W);
    localparam int LSB = i * SUB_W;
    sct_field #(.W(FW), .LIMIT(LIM)) u_field (
      .clk       (clk),
      .rst       (rst),
      .load_en   (load_i),
      .load_val  (load_value_i[LSB +: FW]),
      .step_in   (carry[i]),
      .value     (stamp_o[LSB +: FW]),
      .carry_out (carry[i+1])
    );
  end

  sct_snap #(.STAMP_W(STAMP_W), .LOW_W(SUB_W)) u_snap (
    .clk       (clk),
    .rst       (rst),
    .sync_in   (frame_sync_i),
    .high_rate (high_rate_i),
    .stamp_in  (stamp_o),
    .out_valid (frame_stamp_valid_o),
    .out_ready (frame_stamp_ready_i),
    .out_data  (frame_stamp_o)
  );

  // The frame-field carry marks the 90 -> 0 rollover with the image step
  sct_mode #(.MODE_W(MODE_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .req_valid (mode_req_valid_i),
    .req_data  (mode_req_i),
    .req_ready (mode_req_ready_o),
    .boundary  (carry[3]),
    .mode      (mode_o)
  );
endmodule

// File: rtl/sct_checker.sv
module sct_checker #(
  parameter int RIM_W  = 24,
  parameter int SUB_W  = 8,
  parameter int MOD_A  = 8,
  parameter int MOD_B  = 10,
  parameter int MOD_C  = 91,
  parameter int MODE_W = 4,
  localparam int STAMP_W = RIM_W + 3 * SUB_W
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_i,
  input logic               load_i,
  input logic [STAMP_W-1:0] load_value_i,
  input logic               high_rate_i,
  input logic               frame_sync_i,
  input logic [STAMP_W-1:0] stamp_o,
  input logic               frame_stamp_valid_o,
  input logic               frame_stamp_ready_i,
  input logic [STAMP_W-1:0] frame_stamp_o,
  input logic               mode_req_valid_i,
  input logic               mode_req_ready_o,
  input logic [MODE_W-1:0]  mode_o
);
  logic             at_boundary;
  logic             load_legal;
  logic [RIM_W-1:0] rim_now;

  assign rim_now     = stamp_o[STAMP_W-1 -: RIM_W];
  assign at_boundary = tick_i && !load_i &&
                       (stamp_o[3*SUB_W-1:0] == {SUB_W'(MOD_C-1), SUB_W'(MOD_B-1), SUB_W'(MOD_A-1)});
  assign load_legal  = (load_value_i[SUB_W-1:0] < SUB_W'(MOD_A)) &&
                       (load_value_i[2*SUB_W-1:SUB_W] < SUB_W'(MOD_B)) &&
                       (load_value_i[3*SUB_W-1:2*SUB_W] < SUB_W'(MOD_C));

  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (rst)
    (stamp_o[SUB_W-1:0] < SUB_W'(MOD_A)) && (stamp_o[2*SUB_W-1:SUB_W] < SUB_W'(MOD_B)) &&
    (stamp_o[3*SUB_W-1:2*SUB_W] < SUB_W'(MOD_C)));  // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i && !load_i |=> $stable(stamp_o));  // R5
  AST_RIM_STEP: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (rim_now == $past(rim_now)) || (rim_now == $past(rim_now) + 1'b1));  // R4
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_i && load_legal |=> stamp_o == $past(load_value_i));  // R6
  AST_STAMP_AT_SYNC: assert property (@(posedge clk) disable iff (rst)
    frame_sync_i |=> frame_stamp_valid_o &&
      (frame_stamp_o[STAMP_W-1:SUB_W] == $past(stamp_o[STAMP_W-1:SUB_W])));  // R7
  AST_LOW_RATE_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_sync_i && !high_rate_i |=> frame_stamp_o[SUB_W-1:0] == '0);  // R8
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
    frame_stamp_valid_o && !frame_stamp_ready_i && !frame_sync_i |=>
      frame_stamp_valid_o && $stable(frame_stamp_o));  // R9
  AST_MODE_DEFER: assert property (@(posedge clk) disable iff (rst)
    !at_boundary |=> $stable(mode_o));  // R10
  AST_MODE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mode_req_valid_i && mode_req_ready_o |=> !mode_req_ready_o);  // R10
endmodule

bind sct_timestamp sct_checker #(
  .RIM_W(RIM_W), .SUB_W(SUB_W), .MOD_A(MOD_A), .MOD_B(MOD_B), .MOD_C(MOD_C), .MODE_W(MODE_W)
) u_sct_checker (
  .clk                 (clk),
  .rst                 (rst),
  .tick_i              (tick_i),
  .load_i              (load_i),
  .load_value_i        (load_value_i),
  .high_rate_i         (high_rate_i),
  .frame_sync_i        (frame_sync_i),
  .stamp_o             (stamp_o),
  .frame_stamp_valid_o (frame_stamp_valid_o),
  .frame_stamp_ready_i (frame_stamp_ready_i),
  .frame_stamp_o       (frame_stamp_o),
  .mode_req_valid_i    (mode_req_valid_i),
  .mode_req_ready_o    (mode_req_ready_o),
  .mode_o              (mode_o)
);

// File: tb/sct_timestamp_test.sv
module sct_timestamp_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        load_i = 1'b0;
  logic [47:0] load_value_i = '0;
  logic        high_rate_i = 1'b0;
  logic        frame_sync_i = 1'b0;
  logic [47:0] stamp_o;
  logic        frame_stamp_valid_o;
  logic        frame_stamp_ready_i = 1'b0;
  logic [47:0] frame_stamp_o;
  logic        mode_req_valid_i = 1'b0;
  logic [3:0]  mode_req_i = '0;
  logic        mode_req_ready_o;
  logic [3:0]  mode_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  sct_timestamp uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i), .load_value_i(load_value_i),
    .high_rate_i(high_rate_i), .frame_sync_i(frame_sync_i), .stamp_o(stamp_o),
    .frame_stamp_valid_o(frame_stamp_valid_o), .frame_stamp_ready_i(frame_stamp_ready_i),
    .frame_stamp_o(frame_stamp_o), .mode_req_valid_i(mode_req_valid_i), .mode_req_i(mode_req_i),
    .mode_req_ready_o(mode_req_ready_o), .mode_o(mode_o)
  );

  function automatic logic [47:0] mk(int r, int f, int i, int s);
    return {r[23:0], f[7:0], i[7:0], s[7:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc();
    cyc();
    rst = 1'b0;
  endtask

  task automatic load_word(input logic [47:0] v, input bit with_tick);
    load_i = 1'b1;
    load_value_i = v;
    tick_i = with_tick;
    cyc();
    load_i = 1'b0;
    tick_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 stamp", 64'(stamp_o), 64'(0));
    chk("R1 capture valid", 64'(frame_stamp_valid_o), 64'(0));
    chk("R1 mode", 64'(mode_o), 64'(0));
    chk("R1 mode ready", 64'(mode_req_ready_o), 64'(1));
  endtask

  task automatic t_low_steps();
    tick_i = 1'b1;
    cyc();
    tick_i = 1'b0;
    chk("R2 first tick", 64'(stamp_o), 64'(mk(0, 0, 0, 1)));
    repeat (3) cyc();
    chk("R5 hold without tick", 64'(stamp_o), 64'(mk(0, 0, 0, 1)));
    tick_i = 1'b1;
    repeat (7) cyc();
    tick_i = 1'b0;
    chk("R2 sub-step wrap", 64'(stamp_o), 64'(mk(0, 0, 1, 0)));
  endtask

  task automatic t_full_period();
    do_reset();
    tick_i = 1'b1;
    repeat (80) cyc();
    chk("R3 interrupt carry", 64'(stamp_o), 64'(mk(0, 1, 0, 0)));
    repeat (7199) cyc();
    chk("R3 one before rollover", 64'(stamp_o), 64'(mk(0, 90, 9, 7)));
    cyc();
    tick_i = 1'b0;
    chk("R3 full period", 64'(stamp_o), 64'(mk(1, 0, 0, 0)));
  endtask

  task automatic t_wrap_and_load();
    load_word(mk(24'hFFFFFF, 90, 9, 7), 1'b0);
    chk("R6 load", 64'(stamp_o), 64'(mk(24'hFFFFFF, 90, 9, 7)));
    tick_i = 1'b1;
    cyc();
    tick_i = 1'b0;
    chk("R4 image wrap", 64'(stamp_o), 64'(0));
    load_word(mk(33, 12, 3, 2), 1'b1);
    chk("R6 load beats tick", 64'(stamp_o), 64'(mk(33, 12, 3, 2)));
    load_word(mk(5, 95, 12, 9), 1'b0);
    chk("R6 clamp", 64'(stamp_o), 64'(mk(5, 0, 0, 0)));
  endtask

  task automatic t_capture();
    load_word(mk(100, 3, 4, 5), 1'b0);
    frame_sync_i = 1'b1;
    tick_i = 1'b1;
    high_rate_i = 1'b1;
    cyc();
    frame_sync_i = 1'b0;
    tick_i = 1'b0;
    chk("R7 capture valid", 64'(frame_stamp_valid_o), 64'(1));
    chk("R7 R8 capture high rate", 64'(frame_stamp_o), 64'(mk(100, 3, 4, 5)));
    chk("R2 tick with sync", 64'(stamp_o), 64'(mk(100, 3, 4, 6)));
    repeat (3) cyc();
    chk("R9 held valid", 64'(frame_stamp_valid_o), 64'(1));
    chk("R9 held data", 64'(frame_stamp_o), 64'(mk(100, 3, 4, 5)));
    high_rate_i = 1'b0;
    frame_sync_i = 1'b1;
    cyc();
    frame_sync_i = 1'b0;
    chk("R8 low-rate masking", 64'(frame_stamp_o), 64'(mk(100, 3, 4, 0)));
    frame_stamp_ready_i = 1'b1;
    cyc();
    chk("R9 drained", 64'(frame_stamp_valid_o), 64'(0));
    high_rate_i = 1'b1;
    frame_sync_i = 1'b1;
    cyc();
    frame_sync_i = 1'b0;
    chk("R9 sync with ready", 64'(frame_stamp_valid_o), 64'(1));
    chk("R9 sync with ready data", 64'(frame_stamp_o), 64'(mk(100, 3, 4, 6)));
    cyc();
    frame_stamp_ready_i = 1'b0;
    chk("R9 second drain", 64'(frame_stamp_valid_o), 64'(0));
  endtask

  task automatic t_mode();
    load_word(mk(7, 90, 9, 6), 1'b0);
    mode_req_valid_i = 1'b1;
    mode_req_i = 4'd3;
    cyc();
    chk("R10 busy after accept", 64'(mode_req_ready_o), 64'(0));
    chk("R10 not yet applied", 64'(mode_o), 64'(0));
    mode_req_i = 4'd5;
    tick_i = 1'b1;
    cyc();
    chk("R10 held before rollover", 64'(mode_o), 64'(0));
    cyc();
    tick_i = 1'b0;
    mode_req_valid_i = 1'b0;
    chk("R3 rollover into image", 64'(stamp_o), 64'(mk(8, 0, 0, 0)));
    chk("R10 applied at rollover", 64'(mode_o), 64'(3));
    chk("R10 ready again", 64'(mode_req_ready_o), 64'(1));
    load_word(mk(8, 90, 9, 7), 1'b0);
    tick_i = 1'b1;
    cyc();
    tick_i = 1'b0;
    chk("R10 blocked request not taken", 64'(mode_o), 64'(3));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_reset();
    t_low_steps();
    t_full_period();
    t_wrap_and_load();
    t_capture();
    t_mode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule